// File: doc/BRIEF.md
# Aliased Floating-Point Register File

This block holds 64 single-precision entries of 32 bits each and lets the rest of a floating-point unit reach them through four views of the same storage. The single view addresses any entry directly. The double view treats two neighbouring entries as one 64-bit value. The vector view addresses groups of four entries. The matrix view addresses groups of sixteen entries. Every view has one read port and one write port, so up to four writes can land in the same clock cycle.

Reads are combinational. Writes take effect on the rising clock edge. When more than one write port targets the same entry in a cycle, a fixed priority picks the winner. A double-view index must be even. An odd index raises an error flag on that port. An odd double read returns zero, and an odd double write is dropped.

Top module: `fpr_alias_file`

## Requirements
- R1: While `rst_n` is low at a rising edge, all 64 entries are cleared to zero, and every read view returns zero afterwards until a write occurs.
- R2: `sgl_rd_data` always shows entry `sgl_rd_idx`. When `sgl_wr_en` is high at a rising edge, entry `sgl_wr_idx` takes `sgl_wr_data`.
- R3: A double write at an even index i stores bits 63:32 of `dbl_wr_data` into entry i and bits 31:0 into entry i+1.
- R4: For an even `dbl_rd_idx` i, `dbl_rd_data` is {entry i, entry i+1} and `dbl_rd_err` is low. For an odd index, `dbl_rd_err` is high and `dbl_rd_data` is zero.
- R5: When `dbl_wr_en` is high with an odd `dbl_wr_idx`, `dbl_wr_err` is high in that cycle and the double port changes no entry. `dbl_wr_err` is low at all other times.
- R6: The vector view keeps only bits 3:0 of its 8-bit index (k). Both read and write address entry 4·k.
- R7: The matrix view keeps only bits 1:0 of its 8-bit index (k). Both read and write address entry 16·k.
- R8: When several writes hit the same entry in one cycle, the priority from highest to lowest is double, single, vector, matrix.
- R9: A read in the same cycle as a write to the same entry returns the value held before the edge. The new value appears only after the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all writes are sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset that clears every entry |
| sgl_rd_idx | input | 6 | Single-view read index |
| sgl_rd_data | output | 32 | Entry at `sgl_rd_idx` |
| sgl_wr_en | input | 1 | Single-view write enable |
| sgl_wr_idx | input | 6 | Single-view write index |
| sgl_wr_data | input | 32 | Single-view write value |
| dbl_rd_idx | input | 6 | Double-view read index (even for legal use) |
| dbl_rd_data | output | 64 | {entry i, entry i+1}, or zero when the index is odd |
| dbl_rd_err | output | 1 | High when `dbl_rd_idx` is odd |
| dbl_wr_en | input | 1 | Double-view write enable |
| dbl_wr_idx | input | 6 | Double-view write index (even for legal use) |
| dbl_wr_data | input | 64 | Upper half goes to entry i, lower half to entry i+1 |
| dbl_wr_err | output | 1 | High when a double write is requested at an odd index |
| vec_rd_idx | input | 8 | Vector-view read index; bits 3:0 are used |
| vec_rd_data | output | 32 | Base entry of the addressed vector |
| vec_wr_en | input | 1 | Vector-view write enable |
| vec_wr_idx | input | 8 | Vector-view write index; bits 3:0 are used |
| vec_wr_data | input | 32 | Value for the base entry of the vector |
| mtx_rd_idx | input | 8 | Matrix-view read index; bits 1:0 are used |
| mtx_rd_data | output | 32 | Base entry of the addressed matrix |
| mtx_wr_en | input | 1 | Matrix-view write enable |
| mtx_wr_idx | input | 8 | Matrix-view write index; bits 1:0 are used |
| mtx_wr_data | input | 32 | Value for the base entry of the matrix |

## Verification
The hardest case to reach from the ports is a single cycle in which three or four write ports land on one entry. Random indices seldom line up that way, because the vector and matrix views can only reach every fourth or every sixteenth entry. The bench therefore runs directed cycles in which all four ports target entry 32, plus single-against-vector and vector-against-matrix collisions. It then runs random traffic whose single and double indices are often drawn from the small set of entries that the vector and matrix views can reach. The vector and matrix indices are drawn over all 8 bits, so the upper bits that should be ignored are exercised at the same time.

// File: rtl/fpr_pkg.sv
// Package: shared types for the aliased floating-point register file.
// Assumes: write sources are ranked by the merge logic; the enum order is
// documentation only and carries no priority by itself.
package fpr_pkg;

    // Which write port supplies an entry's next value in a cycle.
    typedef enum logic [2:0] {
        WSRC_NONE = 3'd0,
        WSRC_MTX  = 3'd1,
        WSRC_VEC  = 3'd2,
        WSRC_SGL  = 3'd3,
        WSRC_DBL  = 3'd4
    } wsrc_e;

endpackage

// File: rtl/fpr_addr_map.sv
// Module: fpr_addr_map
// Turns the four view indices into flat entry addresses.
// Assumes: N, VEC_SPAN and MTX_SPAN are powers of two, and VIEW_W is at least
// as wide as the vector and matrix index fields.
module fpr_addr_map #(
    parameter int N        = 64,
    parameter int VEC_SPAN = 4,
    parameter int MTX_SPAN = 16,
    parameter int VIEW_W   = 8,
    localparam int IDX_W   = $clog2(N),
    localparam int VB      = $clog2(N / VEC_SPAN),
    localparam int VS      = $clog2(VEC_SPAN),
    localparam int MB      = $clog2(N / MTX_SPAN),
    localparam int MS      = $clog2(MTX_SPAN)
) (
    input  logic [IDX_W-1:0]  dbl_idx,
    input  logic [VIEW_W-1:0] vec_idx,
    input  logic [VIEW_W-1:0] mtx_idx,
    output logic [IDX_W-1:0]  dbl_hi_addr,
    output logic [IDX_W-1:0]  dbl_lo_addr,
    output logic              dbl_legal,
    output logic [IDX_W-1:0]  vec_addr,
    output logic [IDX_W-1:0]  mtx_addr
);

    logic unused_view_bits;

    // Pair addressing: the even index names the upper half, its odd partner the lower half.
    always_comb begin
        dbl_legal   = ~dbl_idx[0];
        dbl_hi_addr = dbl_idx;
        dbl_lo_addr = {dbl_idx[IDX_W-1:1], 1'b1};
    end

    // Group addressing: keep the low index bits, then scale by the group span.
    always_comb begin
        vec_addr = IDX_W'({vec_idx[VB-1:0], {VS{1'b0}}});
        mtx_addr = IDX_W'({mtx_idx[MB-1:0], {MS{1'b0}}});
    end

    // The upper index bits are ignored on purpose.
    assign unused_view_bits = ^{vec_idx, mtx_idx};

endmodule

// File: rtl/fpr_write_merge.sv
// Module: fpr_write_merge
// For each entry, picks which write port (if any) updates it this cycle.
// Priority from highest to lowest: double, single, vector, matrix.
// Assumes: the double request is already qualified by index legality.
module fpr_write_merge
    import fpr_pkg::*;
#(
    parameter int N      = 64,
    parameter int W      = 32,
    localparam int IDX_W = $clog2(N),
    localparam int DW    = 2 * W
) (
    input  logic                  sgl_en,
    input  logic [IDX_W-1:0]      sgl_addr,
    input  logic [W-1:0]          sgl_data,
    input  logic                  dbl_ok,
    input  logic [IDX_W-1:0]      dbl_hi_addr,
    input  logic [IDX_W-1:0]      dbl_lo_addr,
    input  logic [DW-1:0]         dbl_data,
    input  logic                  vec_en,
    input  logic [IDX_W-1:0]      vec_addr,
    input  logic [W-1:0]          vec_data,
    input  logic                  mtx_en,
    input  logic [IDX_W-1:0]      mtx_addr,
    input  logic [W-1:0]          mtx_data,
    output logic [N-1:0]          wen,
    output logic [N-1:0][W-1:0]   wdata
);

    for (genvar e = 0; e < N; e++) begin : g_ent
        wsrc_e sel;

        // Rank the requests aimed at this entry; later tests override earlier ones.
        always_comb begin
            sel = WSRC_NONE;
            if (mtx_en && (mtx_addr == IDX_W'(e)))
                sel = WSRC_MTX;
            if (vec_en && (vec_addr == IDX_W'(e)))
                sel = WSRC_VEC;
            if (sgl_en && (sgl_addr == IDX_W'(e)))
                sel = WSRC_SGL;
            if (dbl_ok && ((dbl_hi_addr == IDX_W'(e)) || (dbl_lo_addr == IDX_W'(e))))
                sel = WSRC_DBL;
        end

        // Route the winning source's value to this entry.
        always_comb begin
            unique case (sel)
                WSRC_DBL: wdata[e] = (dbl_hi_addr == IDX_W'(e)) ? dbl_data[DW-1:W]
                                                                 : dbl_data[W-1:0];
                WSRC_SGL: wdata[e] = sgl_data;
                WSRC_VEC: wdata[e] = vec_data;
                WSRC_MTX: wdata[e] = mtx_data;
                default:  wdata[e] = '0;
            endcase
        end

        assign wen[e] = (sel != WSRC_NONE);
    end

endmodule

// File: rtl/fpr_read_mux.sv
// Module: fpr_read_mux
// Combinational read selection for the four views from the flat storage.
// Assumes: addresses come already scaled from fpr_addr_map.
module fpr_read_mux #(
    parameter int N      = 64,
    parameter int W      = 32,
    localparam int IDX_W = $clog2(N),
    localparam int DW    = 2 * W
) (
    input  logic [N-1:0][W-1:0] mem,
    input  logic [IDX_W-1:0]    sgl_addr,
    input  logic [IDX_W-1:0]    dbl_hi_addr,
    input  logic [IDX_W-1:0]    dbl_lo_addr,
    input  logic                dbl_legal,
    input  logic [IDX_W-1:0]    vec_addr,
    input  logic [IDX_W-1:0]    mtx_addr,
    output logic [W-1:0]        sgl_data,
    output logic [DW-1:0]       dbl_data,
    output logic [W-1:0]        vec_data,
    output logic [W-1:0]        mtx_data
);

    // Single, vector and matrix views each return one entry.
    always_comb begin
        sgl_data = mem[sgl_addr];
        vec_data = mem[vec_addr];
        mtx_data = mem[mtx_addr];
    end

    // The double view joins two entries, and is forced to zero for an odd index.
    always_comb begin
        dbl_data = dbl_legal ? {mem[dbl_hi_addr], mem[dbl_lo_addr]} : '0;
    end

endmodule

// File: rtl/fpr_alias_file.sv
// Module: fpr_alias_file (top)
// A 64 x 32-bit register file reached through single, double, vector and
// matrix views. Reads are combinational and writes are synchronous.
// Assumes: the clock is always running; rst_n is synchronous and active low.
module fpr_alias_file #(
    parameter int N        = 64,
    parameter int W        = 32,
    parameter int VEC_SPAN = 4,
    parameter int MTX_SPAN = 16,
    parameter int VIEW_W   = 8,
    localparam int IDX_W   = $clog2(N),
    localparam int DW      = 2 * W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  sgl_rd_idx,
    output logic [W-1:0]      sgl_rd_data,
    input  logic              sgl_wr_en,
    input  logic [IDX_W-1:0]  sgl_wr_idx,
    input  logic [W-1:0]      sgl_wr_data,
    input  logic [IDX_W-1:0]  dbl_rd_idx,
    output logic [DW-1:0]     dbl_rd_data,
    output logic              dbl_rd_err,
    input  logic              dbl_wr_en,
    input  logic [IDX_W-1:0]  dbl_wr_idx,
    input  logic [DW-1:0]     dbl_wr_data,
    output logic              dbl_wr_err,
    input  logic [VIEW_W-1:0] vec_rd_idx,
    output logic [W-1:0]      vec_rd_data,
    input  logic              vec_wr_en,
    input  logic [VIEW_W-1:0] vec_wr_idx,
    input  logic [W-1:0]      vec_wr_data,
    input  logic [VIEW_W-1:0] mtx_rd_idx,
    output logic [W-1:0]      mtx_rd_data,
    input  logic              mtx_wr_en,
    input  logic [VIEW_W-1:0] mtx_wr_idx,
    input  logic [W-1:0]      mtx_wr_data
);

    logic [N-1:0][W-1:0] mem_q;
    logic [N-1:0]        wen;
    logic [N-1:0][W-1:0] wdata;

    logic [IDX_W-1:0] rd_hi, rd_lo, rd_vec, rd_mtx;
    logic             rd_legal;
    logic [IDX_W-1:0] wr_hi, wr_lo, wr_vec, wr_mtx;
    logic             wr_legal;

    // Read-side index translation.
    fpr_addr_map #(.N(N), .VEC_SPAN(VEC_SPAN), .MTX_SPAN(MTX_SPAN), .VIEW_W(VIEW_W)) u_rd_map (
        .dbl_idx     (dbl_rd_idx),
        .vec_idx     (vec_rd_idx),
        .mtx_idx     (mtx_rd_idx),
        .dbl_hi_addr (rd_hi),
        .dbl_lo_addr (rd_lo),
        .dbl_legal   (rd_legal),
        .vec_addr    (rd_vec),
        .mtx_addr    (rd_mtx)
    );

    // Write-side index translation.
    fpr_addr_map #(.N(N), .VEC_SPAN(VEC_SPAN), .MTX_SPAN(MTX_SPAN), .VIEW_W(VIEW_W)) u_wr_map (
        .dbl_idx     (dbl_wr_idx),
        .vec_idx     (vec_wr_idx),
        .mtx_idx     (mtx_wr_idx),
        .dbl_hi_addr (wr_hi),
        .dbl_lo_addr (wr_lo),
        .dbl_legal   (wr_legal),
        .vec_addr    (wr_vec),
        .mtx_addr    (wr_mtx)
    );

    // Per-entry priority merge of the four write ports.
    fpr_write_merge #(.N(N), .W(W)) u_merge (
        .sgl_en      (sgl_wr_en),
        .sgl_addr    (sgl_wr_idx),
        .sgl_data    (sgl_wr_data),
        .dbl_ok      (dbl_wr_en & wr_legal),
        .dbl_hi_addr (wr_hi),
        .dbl_lo_addr (wr_lo),
        .dbl_data    (dbl_wr_data),
        .vec_en      (vec_wr_en),
        .vec_addr    (wr_vec),
        .vec_data    (vec_wr_data),
        .mtx_en      (mtx_wr_en),
        .mtx_addr    (wr_mtx),
        .mtx_data    (mtx_wr_data),
        .wen         (wen),
        .wdata       (wdata)
    );

    // Storage: clear on reset, otherwise load each entry that the merge selects.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_q <= '0;
        end else begin
            for (int e = 0; e < N; e++) begin
                if (wen[e])
                    mem_q[e] <= wdata[e];
            end
        end
    end

    // Read views.
    fpr_read_mux #(.N(N), .W(W)) u_rd (
        .mem         (mem_q),
        .sgl_addr    (sgl_rd_idx),
        .dbl_hi_addr (rd_hi),
        .dbl_lo_addr (rd_lo),
        .dbl_legal   (rd_legal),
        .vec_addr    (rd_vec),
        .mtx_addr    (rd_mtx),
        .sgl_data    (sgl_rd_data),
        .dbl_data    (dbl_rd_data),
        .vec_data    (vec_rd_data),
        .mtx_data    (mtx_rd_data)
    );

    // Error flags for odd double indices.
    always_comb begin
        dbl_rd_err = ~rd_legal;
        dbl_wr_err = dbl_wr_en & ~wr_legal;
    end

endmodule

// File: rtl/fpr_alias_chk.sv
// Module: fpr_alias_chk
// Assertion checker bound to fpr_alias_file. It observes the ports and the
// storage and checks the view mapping and write rules over time.
// Assumes: the same parameter values as the bound top.
module fpr_alias_chk #(
    parameter int N        = 64,
    parameter int W        = 32,
    parameter int VEC_SPAN = 4,
    parameter int MTX_SPAN = 16,
    parameter int VIEW_W   = 8,
    localparam int IDX_W   = $clog2(N),
    localparam int DW      = 2 * W,
    localparam int VB      = $clog2(N / VEC_SPAN),
    localparam int VS      = $clog2(VEC_SPAN),
    localparam int MB      = $clog2(N / MTX_SPAN),
    localparam int MS      = $clog2(MTX_SPAN)
) (
    input logic                clk,
    input logic                rst_n,
    input logic [N-1:0][W-1:0] mem,
    input logic                sgl_wr_en,
    input logic [IDX_W-1:0]    sgl_wr_idx,
    input logic [W-1:0]        sgl_wr_data,
    input logic                dbl_wr_en,
    input logic [IDX_W-1:0]    dbl_wr_idx,
    input logic [DW-1:0]       dbl_wr_data,
    input logic                dbl_wr_err,
    input logic                vec_wr_en,
    input logic                mtx_wr_en,
    input logic [IDX_W-1:0]    dbl_rd_idx,
    input logic [DW-1:0]       dbl_rd_data,
    input logic                dbl_rd_err,
    input logic [VIEW_W-1:0]   vec_rd_idx,
    input logic [W-1:0]        vec_rd_data,
    input logic [VIEW_W-1:0]   mtx_rd_idx,
    input logic [W-1:0]        mtx_rd_data
);

    p_rst_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (mem == '0));

    p_sgl_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sgl_wr_en && !dbl_wr_en) |=> (mem[$past(sgl_wr_idx)] == $past(sgl_wr_data)));

    p_dbl_write_hi_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (dbl_wr_en && !dbl_wr_idx[0]) |=> (mem[$past(dbl_wr_idx)] == $past(dbl_wr_data[DW-1:W])));

    p_dbl_write_lo_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (dbl_wr_en && !dbl_wr_idx[0]) |=>
            (mem[$past(dbl_wr_idx) | IDX_W'(1)] == $past(dbl_wr_data[W-1:0])));

    p_dbl_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !dbl_rd_err |-> (dbl_rd_data == {mem[dbl_rd_idx], mem[dbl_rd_idx | IDX_W'(1)]}));

    p_dbl_read_odd_r4: assert property (@(posedge clk) disable iff (!rst_n)
        dbl_rd_idx[0] |-> (dbl_rd_err && (dbl_rd_data == '0)));

    p_odd_nowrite_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (dbl_wr_err && !sgl_wr_en && !vec_wr_en && !mtx_wr_en) |=> $stable(mem));

    p_err_only_odd_r5: assert property (@(posedge clk) disable iff (!rst_n)
        dbl_wr_err |-> (dbl_wr_en && dbl_wr_idx[0]));

    p_vec_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |-> (vec_rd_data == mem[IDX_W'({vec_rd_idx[VB-1:0], {VS{1'b0}}})]));

    p_mtx_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |-> (mtx_rd_data == mem[IDX_W'({mtx_rd_idx[MB-1:0], {MS{1'b0}}})]));

endmodule

bind fpr_alias_file fpr_alias_chk #(
    .N(N), .W(W), .VEC_SPAN(VEC_SPAN), .MTX_SPAN(MTX_SPAN), .VIEW_W(VIEW_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mem         (mem_q),
    .sgl_wr_en   (sgl_wr_en),
    .sgl_wr_idx  (sgl_wr_idx),
    .sgl_wr_data (sgl_wr_data),
    .dbl_wr_en   (dbl_wr_en),
    .dbl_wr_idx  (dbl_wr_idx),
    .dbl_wr_data (dbl_wr_data),
    .dbl_wr_err  (dbl_wr_err),
    .vec_wr_en   (vec_wr_en),
    .mtx_wr_en   (mtx_wr_en),
    .dbl_rd_idx  (dbl_rd_idx),
    .dbl_rd_data (dbl_rd_data),
    .dbl_rd_err  (dbl_rd_err),
    .vec_rd_idx  (vec_rd_idx),
    .vec_rd_data (vec_rd_data),
    .mtx_rd_idx  (mtx_rd_idx),
    .mtx_rd_data (mtx_rd_data)
);

// File: tb/tb_fpr_alias_file.sv
`timescale 1ns/1ps
module tb_fpr_alias_file;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  sgl_rd_idx = '0;
    logic [31:0] sgl_rd_data;
    logic        sgl_wr_en = 1'b0;
    logic [5:0]  sgl_wr_idx = '0;
    logic [31:0] sgl_wr_data = '0;
    logic [5:0]  dbl_rd_idx = '0;
    logic [63:0] dbl_rd_data;
    logic        dbl_rd_err;
    logic        dbl_wr_en = 1'b0;
    logic [5:0]  dbl_wr_idx = '0;
    logic [63:0] dbl_wr_data = '0;
    logic        dbl_wr_err;
    logic [7:0]  vec_rd_idx = '0;
    logic [31:0] vec_rd_data;
    logic        vec_wr_en = 1'b0;
    logic [7:0]  vec_wr_idx = '0;
    logic [31:0] vec_wr_data = '0;
    logic [7:0]  mtx_rd_idx = '0;
    logic [31:0] mtx_rd_data;
    logic        mtx_wr_en = 1'b0;
    logic [7:0]  mtx_wr_idx = '0;
    logic [31:0] mtx_wr_data = '0;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;
    logic [31:0] model [64];

    always #2 clk = ~clk;

    fpr_alias_file dut (.*);

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] exp_dbl(input logic [5:0] i);
        return i[0] ? 64'd0 : {model[i], model[{i[5:1], 1'b1}]};
    endfunction

    function automatic logic [31:0] exp_vec(input logic [7:0] i);
        return model[{i[3:0], 2'b00}];
    endfunction

    function automatic logic [31:0] exp_mtx(input logic [7:0] i);
        return model[{i[1:0], 4'b0000}];
    endfunction

    // Apply the priority in reverse: lowest first, so higher sources overwrite.
    task automatic model_write();
        if (mtx_wr_en) model[{mtx_wr_idx[1:0], 4'b0000}] = mtx_wr_data;
        if (vec_wr_en) model[{vec_wr_idx[3:0], 2'b00}] = vec_wr_data;
        if (sgl_wr_en) model[sgl_wr_idx] = sgl_wr_data;
        if (dbl_wr_en && !dbl_wr_idx[0]) begin
            model[dbl_wr_idx] = dbl_wr_data[63:32];
            model[{dbl_wr_idx[5:1], 1'b1}] = dbl_wr_data[31:0];
        end
    endtask

    task automatic check_views();
        chk("R2 single read", {32'd0, sgl_rd_data}, {32'd0, model[sgl_rd_idx]});
        chk("R4 double read", dbl_rd_data, exp_dbl(dbl_rd_idx));
        chk("R4 double read err", {63'd0, dbl_rd_err}, {63'd0, dbl_rd_idx[0]});
        chk("R5 double write err", {63'd0, dbl_wr_err}, {63'd0, dbl_wr_en & dbl_wr_idx[0]});
        chk("R6 vector read", {32'd0, vec_rd_data}, {32'd0, exp_vec(vec_rd_idx)});
        chk("R7 matrix read", {32'd0, mtx_rd_data}, {32'd0, exp_mtx(mtx_rd_idx)});
    endtask

    // Caller sets inputs just after a falling edge; checks run before the rising edge.
    task automatic cycle();
        #0.5;
        check_views();
        @(posedge clk);
        model_write();
        #0.1;
        sgl_wr_en = 1'b0;
        dbl_wr_en = 1'b0;
        vec_wr_en = 1'b0;
        mtx_wr_en = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        foreach (model[e]) model[e] = '0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [31:0] seed_v;
        seed_v = $urandom(32'd2718);

        // R1: reset clears every entry.
        do_reset();
        for (int e = 0; e < 64; e++) begin
            sgl_rd_idx = 6'(e);
            #0.1;
            chk("R1 reset clear", {32'd0, sgl_rd_data}, 64'd0);
        end

        // R2/R9: single write; a read in the same cycle still sees the old value.
        @(negedge clk);
        sgl_wr_en = 1'b1; sgl_wr_idx = 6'd5; sgl_wr_data = 32'hCAFE_0005; sgl_rd_idx = 6'd5;
        #0.3;
        chk("R9 read before edge", {32'd0, sgl_rd_data}, 64'd0);
        cycle();
        chk("R2 single write", {32'd0, sgl_rd_data}, {32'd0, 32'hCAFE_0005});

        // R3/R4: double write at an even index, then read back.
        @(negedge clk);
        dbl_wr_en = 1'b1; dbl_wr_idx = 6'd10; dbl_wr_data = 64'h1111_2222_3333_4444;
        cycle();
        sgl_rd_idx = 6'd10; #0.1;
        chk("R3 double upper to i", {32'd0, sgl_rd_data}, {32'd0, 32'h1111_2222});
        sgl_rd_idx = 6'd11; dbl_rd_idx = 6'd10; #0.1;
        chk("R3 double lower to i+1", {32'd0, sgl_rd_data}, {32'd0, 32'h3333_4444});
        chk("R4 double join", dbl_rd_data, 64'h1111_2222_3333_4444);

        // R5: odd double write flags an error and leaves entries 13 and 14 alone.
        @(negedge clk);
        dbl_wr_en = 1'b1; dbl_wr_idx = 6'd13; dbl_wr_data = 64'hDEAD_BEEF_DEAD_BEEF;
        #0.3;
        chk("R5 odd write flag", {63'd0, dbl_wr_err}, 64'd1);
        cycle();
        sgl_rd_idx = 6'd13; #0.1;
        chk("R5 odd write no change i", {32'd0, sgl_rd_data}, 64'd0);
        sgl_rd_idx = 6'd14; #0.1;
        chk("R5 odd write no change i+1", {32'd0, sgl_rd_data}, 64'd0);

        // R4: odd double read gives an error and zero data.
        dbl_rd_idx = 6'd11; #0.1;
        chk("R4 odd read err", {63'd0, dbl_rd_err}, 64'd1);
        chk("R4 odd read zero", dbl_rd_data, 64'd0);

        // R6: vector index 0xF7 is masked to 7, which addresses entry 28.
        @(negedge clk);
        vec_wr_en = 1'b1; vec_wr_idx = 8'hF7; vec_wr_data = 32'hA5A5_0028;
        cycle();
        sgl_rd_idx = 6'd28; vec_rd_idx = 8'h37; #0.1;
        chk("R6 vector write entry 28", {32'd0, sgl_rd_data}, {32'd0, 32'hA5A5_0028});
        chk("R6 vector read masked", {32'd0, vec_rd_data}, {32'd0, 32'hA5A5_0028});

        // R7: matrix index 0xFE is masked to 2, which addresses entry 32.
        @(negedge clk);
        mtx_wr_en = 1'b1; mtx_wr_idx = 8'hFE; mtx_wr_data = 32'h5A5A_0032;
        cycle();
        sgl_rd_idx = 6'd32; mtx_rd_idx = 8'h42; #0.1;
        chk("R7 matrix write entry 32", {32'd0, sgl_rd_data}, {32'd0, 32'h5A5A_0032});
        chk("R7 matrix read masked", {32'd0, mtx_rd_data}, {32'd0, 32'h5A5A_0032});

        // R8: all four ports aim at entry 32 (single at 32); the double port wins.
        @(negedge clk);
        dbl_wr_en = 1'b1; dbl_wr_idx = 6'd32; dbl_wr_data = 64'h0D0D_0D0D_0E0E_0E0E;
        sgl_wr_en = 1'b1; sgl_wr_idx = 6'd32; sgl_wr_data = 32'h5151_5151;
        vec_wr_en = 1'b1; vec_wr_idx = 8'd8;  vec_wr_data = 32'h7777_7777;
        mtx_wr_en = 1'b1; mtx_wr_idx = 8'd2;  mtx_wr_data = 32'h9999_9999;
        cycle();
        sgl_rd_idx = 6'd32; #0.1;
        chk("R8 double beats all", {32'd0, sgl_rd_data}, {32'd0, 32'h0D0D_0D0D});

        // R8: single beats vector at entry 40.
        @(negedge clk);
        sgl_wr_en = 1'b1; sgl_wr_idx = 6'd40; sgl_wr_data = 32'h0000_0040;
        vec_wr_en = 1'b1; vec_wr_idx = 8'd10; vec_wr_data = 32'hFFFF_0040;
        cycle();
        sgl_rd_idx = 6'd40; #0.1;
        chk("R8 single beats vector", {32'd0, sgl_rd_data}, {32'd0, 32'h0000_0040});

        // R8: vector beats matrix at entry 48.
        @(negedge clk);
        vec_wr_en = 1'b1; vec_wr_idx = 8'd12; vec_wr_data = 32'h0000_0048;
        mtx_wr_en = 1'b1; mtx_wr_idx = 8'd3;  mtx_wr_data = 32'hFFFF_0048;
        cycle();
        sgl_rd_idx = 6'd48; #0.1;
        chk("R8 vector beats matrix", {32'd0, sgl_rd_data}, {32'd0, 32'h0000_0048});

        // Random traffic, with indices often drawn from group-base entries to force collisions.
        for (int n = 0; n < 3000; n++) begin
            @(negedge clk);
            sgl_wr_en   = 1'($urandom);
            sgl_wr_idx  = ($urandom % 2) ? 6'($urandom) : {2'($urandom), 4'd0};
            sgl_wr_data = $urandom;
            dbl_wr_en   = 1'($urandom);
            dbl_wr_idx  = ($urandom % 2) ? 6'($urandom) : {2'($urandom), 4'd0};
            dbl_wr_data = {$urandom, $urandom};
            vec_wr_en   = 1'($urandom);
            vec_wr_idx  = 8'($urandom);
            vec_wr_data = $urandom;
            mtx_wr_en   = 1'($urandom);
            mtx_wr_idx  = 8'($urandom);
            mtx_wr_data = $urandom;
            sgl_rd_idx  = 6'($urandom);
            dbl_rd_idx  = 6'($urandom);
            vec_rd_idx  = 8'($urandom);
            mtx_rd_idx  = 8'($urandom);
            cycle();
        end

        // R1: a second reset after traffic clears every entry again.
        do_reset();
        for (int e = 0; e < 64; e++) begin
            sgl_rd_idx = 6'(e);
            #0.1;
            chk("R1 reset after traffic", {32'd0, sgl_rd_data}, 64'd0);
        end
        dbl_rd_idx = 6'd62; #0.1;
        chk("R1 double view zero", dbl_rd_data, 64'd0);

        finish_run();
    end

endmodule